// File: doc/BRIEF.md
# Placeholder L2 Cache Controller Register Window

This block gives software the programming interface of a level-2 cache controller while no cache stands behind it. Boot code and drivers can then probe, configure and "maintain" the cache without special cases. It decodes a 4 KB window of 32-bit registers. The window holds the following:

- an identification word;
- a derived cache-type word;
- a one-bit enable;
- auxiliary configuration;
- tag and data RAM latency settings;
- an address-filter range.

Cache maintenance operations always read back as finished. Offsets with nothing behind them are flagged on an error pin.

Every access completes in the cycle its select is high, with no wait states. Read data and the error flag are combinational from the access inputs. Register updates take effect at the following rising clock edge. The block never applies back-pressure, so it has no valid/ready pair: a cycle with `bus_sel` high is one access. The cache-type word is sticky. Each read of it ORs the way-size and associativity bits taken from the auxiliary register into the stored value, and then returns the result.

Top module: `l2stub_regs`

## Requirements
- R1: A read at offset 0x000 returns 0x410000C8. A write there is ignored and flagged as a bad access.
- R2: Only address bits 11:0 are decoded, so an access with any upper address bits behaves as the same access to its low 12 bits.
- R3: Any offset from 0x730 to 0x7FF reads as zero. A write there changes no register. Neither raises the error flag.
- R4: A read at 0x004 forms n = {aux[19:17], aux[16]}. It returns the stored type word ORed with n at bits 21:18 and with n at bits 9:6, and it stores that result.
- R5: The type word starts at parameter TYPE_INIT (default 0x1C100100) and reset restores it.
- R6: The control register at 0x100 keeps only write-data bit 0, and bits 31:1 read as zero.
- R7: Auxiliary (0x104), tag latency (0x108), data latency (0x10C), filter start (0xC00) and filter end (0xC04) are full 32-bit read/write registers.
- R8: After reset the auxiliary register reads 0x02020000, and control, both latency registers and both filter registers read zero.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read zero and ignore writes, without raising the error flag.
- R10: Every other offset reads zero and ignores writes. The same applies to writes at 0x000 and 0x004. Such an access raises `bus_err` in the cycle of the access only.
- R11: The type word changes only on a read at 0x004, never on writes or idle cycles.
- R12: `bus_rdata` is zero in every cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 11:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Bad-offset flag for the current access |

## Verification
A corrupted stored register does not show until software reads that offset, and it then shows in that same cycle. Because of this, the random traffic reads back every register often, and each read is compared against a bench model. A type word that clears bits or moves without a read shows on the next read of 0x004. The fold is sticky, so one wrong accumulation stays visible for every later read until reset. Decode faults show at once on `bus_err` or as non-zero read data from a hole.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;
  localparam int OFS_W  = 12;
  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] ID_WORD  = 32'h410000C8;
  localparam logic [WORD_W-1:0] AUX_INIT = 32'h02020000;

  localparam logic [OFS_W-1:0] OFS_ID     = 12'h000;
  localparam logic [OFS_W-1:0] OFS_TYPE   = 12'h004;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 12'h100;
  localparam logic [OFS_W-1:0] OFS_AUX    = 12'h104;
  localparam logic [OFS_W-1:0] OFS_TAGLAT = 12'h108;
  localparam logic [OFS_W-1:0] OFS_DATLAT = 12'h10C;
  localparam logic [OFS_W-1:0] OFS_FLO    = 12'hC00;
  localparam logic [OFS_W-1:0] OFS_FHI    = 12'hC04;
  localparam logic [OFS_W-1:0] MAINT_LO   = 12'h730;
  localparam logic [OFS_W-1:0] MAINT_HI   = 12'h800;

  localparam int NUM_WIDE = 5;

  typedef enum logic [3:0] {
    RG_ID, RG_TYPE, RG_CTRL, RG_AUX, RG_TAGLAT, RG_DATLAT,
    RG_FLO, RG_FHI, RG_MAINT, RG_HOLE, RG_BAD
  } region_e;

  // Region owned by each full-width storage slot; slot 0 is auxiliary.
  function automatic region_e wide_region(input int slot);
    case (slot)
      0:       return RG_AUX;
      1:       return RG_TAGLAT;
      2:       return RG_DATLAT;
      3:       return RG_FLO;
      default: return RG_FHI;
    endcase
  endfunction

  // Way-size/associativity nibble placed twice into a type word.
  function automatic logic [WORD_W-1:0] type_fold(input logic [WORD_W-1:0] aux);
    logic [3:0] n;
    n = {aux[19:17], aux[16]};
    return {10'b0, n, 8'b0, n, 6'b0};
  endfunction
endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
  import l2stub_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output region_e          region
);
  always_comb begin
    if (ofs >= MAINT_LO && ofs < MAINT_HI) begin
      region = RG_MAINT;
    end else begin
      case (ofs)
        OFS_ID:                   region = RG_ID;
        OFS_TYPE:                 region = RG_TYPE;
        OFS_CTRL:                 region = RG_CTRL;
        OFS_AUX:                  region = RG_AUX;
        OFS_TAGLAT:               region = RG_TAGLAT;
        OFS_DATLAT:               region = RG_DATLAT;
        OFS_FLO:                  region = RG_FLO;
        OFS_FHI:                  region = RG_FHI;
        12'hF40, 12'hF60, 12'hF80: region = RG_HOLE;
        default:                  region = RG_BAD;
      endcase
    end
  end
endmodule

// File: rtl/l2stub_cfg_regs.sv
module l2stub_cfg_regs
  import l2stub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  region_e           region,
  input  logic [WORD_W-1:0] wdata,
  output logic              enable_q,
  output logic [WORD_W-1:0] wide_q [NUM_WIDE]
);
  always_ff @(posedge clk) begin
    if (!rst_n)                          enable_q <= 1'b0;
    else if (wr_stb && region == RG_CTRL) enable_q <= wdata[0];
  end

  for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
    localparam logic [WORD_W-1:0] INIT = (i == 0) ? AUX_INIT : '0;
    localparam region_e OWN = wide_region(i);

    always_ff @(posedge clk) begin
      if (!rst_n)                       wide_q[i] <= INIT;
      else if (wr_stb && region == OWN) wide_q[i] <= wdata;
    end

    p_wide_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && region == OWN) |=> wide_q[i] == $past(wdata));
    p_wide_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && region == OWN) |=> $stable(wide_q[i]));
  end
endmodule

// File: rtl/l2stub_type_acc.sv
module l2stub_type_acc
  import l2stub_pkg::*;
#(
  parameter logic [WORD_W-1:0] TYPE_INIT = 32'h1C100100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_type,
  input  logic [WORD_W-1:0] aux,
  output logic [WORD_W-1:0] type_rd
);
  logic [WORD_W-1:0] type_q;

  assign type_rd = type_q | type_fold(aux);

  always_ff @(posedge clk) begin
    if (!rst_n)       type_q <= TYPE_INIT;
    else if (rd_type) type_q <= type_rd;
  end

  // R4: bits are only ever added to the stored word.
  p_type_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (type_q & $past(type_q)) == $past(type_q));
  p_type_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_type |=> $stable(type_q));
endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
  import l2stub_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [WORD_W-1:0] TYPE_INIT = 32'h1C100100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err
);
  logic              rd_stb, wr_stb;
  region_e           region;
  logic              enable_q;
  logic [WORD_W-1:0] wide_q [NUM_WIDE];
  logic [WORD_W-1:0] type_rd;

  assign rd_stb = bus_sel && !bus_we;
  assign wr_stb = bus_sel && bus_we;

  l2stub_decode u_decode (
    .ofs    (bus_addr[OFS_W-1:0]),
    .region (region)
  );

  l2stub_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .region   (region),
    .wdata    (bus_wdata),
    .enable_q (enable_q),
    .wide_q   (wide_q)
  );

  l2stub_type_acc #(.TYPE_INIT(TYPE_INIT)) u_type (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_type (rd_stb && region == RG_TYPE),
    .aux     (wide_q[0]),
    .type_rd (type_rd)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_stb) begin
      case (region)
        RG_ID:     bus_rdata = ID_WORD;
        RG_TYPE:   bus_rdata = type_rd;
        RG_CTRL:   bus_rdata = {{(WORD_W-1){1'b0}}, enable_q};
        RG_AUX:    bus_rdata = wide_q[0];
        RG_TAGLAT: bus_rdata = wide_q[1];
        RG_DATLAT: bus_rdata = wide_q[2];
        RG_FLO:    bus_rdata = wide_q[3];
        RG_FHI:    bus_rdata = wide_q[4];
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign bus_err = bus_sel &&
                   (region == RG_BAD ||
                    (bus_we && (region == RG_ID || region == RG_TYPE)));

  p_id_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && bus_addr[OFS_W-1:0] == OFS_ID) |-> bus_rdata == ID_WORD);
  p_maint_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && region == RG_MAINT) |-> (bus_rdata == '0 && !bus_err));
  p_ctrl_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && region == RG_CTRL) |-> bus_rdata[WORD_W-1:1] == '0);
  p_err_in_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_sel && bus_rdata == '0));
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> bus_rdata == '0);
endmodule

// File: tb/test_l2stub_regs.sv
`timescale 1ns/1ps
module test_l2stub_regs;
  localparam logic [31:0] TINIT = 32'h1C100100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int n_checks = 0, n_errors = 0;

  // Bench model of the register state.
  logic        m_ctrl;
  logic [31:0] m_aux, m_tag, m_dat, m_flo, m_fhi, m_type;

  always #2.5 clk = ~clk;

  l2stub_regs #(.ADDR_W(32), .TYPE_INIT(TINIT)) i_l2stub_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  function automatic logic [31:0] fold(input logic [31:0] a);
    logic [3:0] n;
    n = {a[19:17], a[16]};
    return (32'(n) << 18) | (32'(n) << 6);
  endfunction

  function automatic bit is_maint(input logic [11:0] o);
    return o >= 12'h730 && o < 12'h800;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] o);
    if (is_maint(o)) return 32'h0;
    case (o)
      12'h000: return 32'h410000C8;
      12'h004: return m_type | fold(m_aux);
      12'h100: return {31'b0, m_ctrl};
      12'h104: return m_aux;
      12'h108: return m_tag;
      12'h10C: return m_dat;
      12'hC00: return m_flo;
      12'hC04: return m_fhi;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_bad(input logic [11:0] o, input bit we);
    if (is_maint(o)) return 1'b0;
    case (o)
      12'h000, 12'h004: return we;
      12'h100, 12'h104, 12'h108, 12'h10C, 12'hC00, 12'hC04,
      12'hF40, 12'hF60, 12'hF80: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 1'b0; m_aux = 32'h02020000; m_tag = '0; m_dat = '0;
    m_flo = '0; m_fhi = '0; m_type = TINIT;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access; outputs sampled 1 ns after the driving falling edge.
  task automatic access(input bit we, input logic [31:0] addr,
                        input logic [31:0] wd, input string req);
    logic [11:0] o;
    logic [31:0] er;
    o = addr[11:0];
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    #1;
    er = we ? 32'h0 : exp_read(o);
    check(req, $sformatf("rdata @%h we=%0d", addr, we), bus_rdata, er);
    check(req, $sformatf("err @%h we=%0d", addr, we), {31'b0, bus_err},
          {31'b0, exp_bad(o, we)});
    if (we && !is_maint(o)) begin
      case (o)
        12'h100: m_ctrl = wd[0];
        12'h104: m_aux = wd;
        12'h108: m_tag = wd;
        12'h10C: m_dat = wd;
        12'hC00: m_flo = wd;
        12'hC04: m_fhi = wd;
        default: ;
      endcase
    end else if (!we && o == 12'h004) begin
      m_type = er;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n, input string req);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = $urandom; bus_wdata = $urandom;
    #1;
    check(req, "idle rdata", bus_rdata, 32'h0);
    check(req, "idle err", {31'b0, bus_err}, 32'h0);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_sel = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  function automatic logic [31:0] pick_addr();
    logic [11:0] o;
    logic [11:0] mapped [12] = '{12'h000, 12'h004, 12'h100, 12'h104,
      12'h108, 12'h10C, 12'hC00, 12'hC04, 12'hF40, 12'hF60, 12'hF80, 12'h004};
    case ($urandom_range(3))
      0, 1: o = mapped[$urandom_range(11)];
      2:    o = 12'(12'h730 + $urandom_range(12'h0CF));
      default: o = 12'($urandom);
    endcase
    return {20'($urandom), o};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R8, R5: reset values.
    access(0, 32'h104, 0, "R8");
    access(0, 32'h100, 0, "R8");
    access(0, 32'h108, 0, "R8");
    access(0, 32'h10C, 0, "R8");
    access(0, 32'hC00, 0, "R8");
    access(0, 32'hC04, 0, "R8");
    access(0, 32'h004, 0, "R5");
    // R1: ID read, write rejected.
    access(0, 32'h000, 0, "R1");
    access(1, 32'h000, 32'hFFFFFFFF, "R1");
    access(0, 32'h000, 0, "R1");
    // R2: upper address bits ignored.
    access(1, 32'hABCDE104, 32'h0000_5A5A, "R2");
    access(0, 32'h00000104, 0, "R2");
    access(0, 32'hFFFFF000, 0, "R2");
    // R6: control keeps bit 0 only.
    access(1, 32'h100, 32'hFFFFFFFF, "R6");
    access(0, 32'h100, 0, "R6");
    access(1, 32'h100, 32'hFFFFFFFE, "R6");
    access(0, 32'h100, 0, "R6");
    // R3: maintenance range edges.
    access(0, 32'h72C, 0, "R10");
    access(0, 32'h730, 0, "R3");
    access(1, 32'h7FC, 32'hFFFFFFFF, "R3");
    access(0, 32'h7FF, 0, "R3");
    access(0, 32'h800, 0, "R10");
    // R9: placeholder offsets.
    access(1, 32'hF40, 32'hFFFFFFFF, "R9");
    access(0, 32'hF60, 0, "R9");
    access(0, 32'hF80, 0, "R9");
    // R10: writes to type and odd offsets.
    access(1, 32'h004, 32'hFFFFFFFF, "R10");
    access(0, 32'h101, 0, "R10");
    // R4, R11: sticky type accumulation.
    access(1, 32'h104, 32'h000F_0000, "R4");
    access(0, 32'h004, 0, "R4");
    access(1, 32'h104, 32'h0, "R11");
    idle(5, "R12");
    access(0, 32'h004, 0, "R11");
    access(1, 32'h104, 32'h0002_0000, "R4");
    access(0, 32'h004, 0, "R4");
    // R5: reset restores the type word.
    do_reset();
    access(0, 32'h004, 0, "R5");

    // Random traffic against the model (R7 and the rest).
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(19) == 0) idle($urandom_range(3), "R12");
      else access(1'($urandom_range(1)), pick_addr(), $urandom, "R7");
    end
    idle(2, "R12");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule